// File: doc/BRIEF.md
# Manchester FSK Tuning Controller

This block sits between a single-bit oversampling modulator and a frequency-shift-keyed oscillator whose frequency is pulled down by switching in tuning capacitors. Each modulator bit arrives with a valid strobe. The bit is resynchronised and then split into two Manchester chips, so the chip rate is twice the bit rate. While a chip is low, the block drives a six-bit capacitor-enable word. While a chip is high, it drives zero.

A three-bit spacing code sets the depth of the low-symbol frequency below the nominal one. Code n, saturated at 5, enables capacitors 0 through n as a thermometer. Codes above 5 give the widest spacing. The code is captured only when a bit starts, so the deviation cannot change inside a bit. With no bit in progress, the output idles at a high chip with every capacitor off. Reset forces the same idle state.

The bit period is `BIT_CYC` clock cycles (even, default 4). Each chip lasts `BIT_CYC/2` cycles.

Top module: `mfsk_tune_ctrl`

## Requirements
- R1: While reset is asserted, and on every cycle with no bit in progress, `chip_o` is 1 and `tune_en` is 6'b000000.
- R2: A bit of value 1 is sent as `chip_o`=1 for the first `BIT_CYC/2` cycles and then `chip_o`=0 for the next `BIT_CYC/2` cycles. A bit of value 0 is sent as 0 and then 1.
- R3: Suppose `bit_vld` is sampled high at clock edge k while the block is idle or finishing a bit. The first chip of that bit then appears after edge k+2, and the bit occupies exactly `BIT_CYC` cycles. Strobes spaced exactly `BIT_CYC` cycles apart give a gap-free chip stream.
- R4: Whenever `chip_o` is 1, `tune_en` is 6'b000000.
- R5: Whenever `chip_o` is 0 and the captured spacing code n is 0 to 5, `tune_en[i]` is 1 exactly for i <= n. For example, code 0 gives 6'b000001 and code 3 gives 6'b001111.
- R6: Captured spacing codes 6 and 7 behave like code 5: a low chip drives 6'b111111.
- R7: `spacing` is sampled only on the clock edge that starts a bit. A change made while a bit is in progress has no effect until the next bit.
- R8: A strobe whose synchronised copy arrives while a bit is in progress, on any cycle except the bit's last, is discarded, and the bit in progress is not altered.
- R9: Asserting `rst_n` low in the middle of a bit returns the outputs to the idle state at once, without waiting for a clock edge, and the interrupted bit is not resumed.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Chip-rate clock |
| rst_n | input | 1 | Active-low reset; asserted asynchronously, released synchronously inside the block |
| bit_vld | input | 1 | Strobe: a new modulator bit is present (asynchronous to the encoder, synchronised inside) |
| bit_in | input | 1 | Modulator output bit, qualified by `bit_vld` |
| spacing | input | 3 | FSK spacing code, captured when a bit starts |
| chip_o | output | 1 | Manchester chip |
| tune_en | output | 6 | Capacitor enables; bit 0 is the first capacitor |

## Verification
Take a strobe sampled at edge k. It passes two synchroniser flops and then one start register, so the first chip is due on the cycle after edge k+2. Each later chip of that bit is due one cycle after the previous one, up to `BIT_CYC` cycles in all.

The driver records the absolute cycle at which each expected chip and enable word is due. The monitor samples on the falling edge. On that cycle it compares the outputs with the queued entry whose due cycle matches. On every other cycle it expects the idle pattern, so an early, late or extra chip shows up as a mismatch.

Spacing changes and second strobes are timed relative to the start edge. This puts them strictly inside a bit, as R7 and R8 require.

// File: rtl/mfsk_pkg.sv
package mfsk_pkg;
  localparam int unsigned SPACE_W = 3;
  localparam int unsigned CAP_W   = 6;
  localparam int unsigned SYNC_STAGES = 2;
endpackage

// File: rtl/mfsk_sync2.sv
module mfsk_sync2 #(
  parameter int unsigned W      = 2,
  parameter int unsigned STAGES = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  logic [W-1:0] pipe_q [STAGES];
  logic [W-1:0] pipe_d [STAGES];

  always_comb begin
    pipe_d[0] = d_i;
    for (int s = 1; s < STAGES; s++) pipe_d[s] = pipe_q[s-1];
  end

  generate
    for (genvar s = 0; s < STAGES; s++) begin : g_stage
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) pipe_q[s] <= '0;
        else        pipe_q[s] <= pipe_d[s];
      end
    end
  endgenerate

  assign q_o = pipe_q[STAGES-1];
endmodule

// File: rtl/mfsk_therm_dec.sv
module mfsk_therm_dec #(
  parameter int unsigned CODE_W = 3,
  parameter int unsigned EN_W   = 6
) (
  input  logic [CODE_W-1:0] code_i,
  output logic [EN_W-1:0]   therm_o
);
  localparam logic [CODE_W-1:0] MAX_CODE = CODE_W'(EN_W - 1);

  logic [CODE_W-1:0] sat_code;

  always_comb begin
    sat_code = (code_i > MAX_CODE) ? MAX_CODE : code_i;
  end

  generate
    for (genvar i = 0; i < EN_W; i++) begin : g_cap
      assign therm_o[i] = (sat_code >= CODE_W'(i));
    end
  endgenerate
endmodule

// File: rtl/mfsk_bit_seq.sv
module mfsk_bit_seq #(
  parameter int unsigned BIT_CYC = 4,
  parameter int unsigned CODE_W  = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              vld_s,
  input  logic              bit_s,
  input  logic [CODE_W-1:0] code_i,
  output logic              active_o,
  output logic              chip_o,
  output logic [CODE_W-1:0] code_o
);
  localparam int unsigned CW   = (BIT_CYC > 2) ? $clog2(BIT_CYC) : 1;
  localparam logic [CW-1:0] LAST = CW'(BIT_CYC - 1);
  localparam logic [CW-1:0] HALF = CW'(BIT_CYC / 2);

  logic              active_q, active_d;
  logic [CW-1:0]     cnt_q, cnt_d;
  logic              bit_q, bit_d;
  logic [CODE_W-1:0] code_q, code_d;
  logic              boundary;
  logic              en_bit;

  always_comb begin
    boundary = !active_q || (cnt_q == LAST);
    en_bit   = boundary && vld_s;
    active_d = active_q;
    cnt_d    = cnt_q;
    bit_d    = bit_q;
    code_d   = code_q;
    if (boundary) begin
      active_d = vld_s;
      cnt_d    = '0;
    end else begin
      cnt_d    = cnt_q + CW'(1);
    end
    if (en_bit) begin
      bit_d  = bit_s;
      code_d = code_i;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      active_q <= 1'b0;
      cnt_q    <= '0;
      bit_q    <= 1'b0;
      code_q   <= '0;
    end else begin
      active_q <= active_d;
      cnt_q    <= cnt_d;
      if (en_bit) begin
        bit_q  <= bit_d;
        code_q <= code_d;
      end
    end
  end

  assign active_o = active_q;
  assign code_o   = code_q;
  assign chip_o   = active_q ? ((cnt_q < HALF) ? bit_q : ~bit_q) : 1'b1;

  AST_CODE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (active_q && cnt_q != '0) |-> $stable(code_q)) else $error("code changed mid-bit"); // R7

  AST_BIT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (active_q && cnt_q != '0) |-> $stable(bit_q)) else $error("bit changed mid-bit"); // R8

  AST_CHIP_SPLIT: assert property (@(posedge clk) disable iff (!rst_n)
    (active_q && cnt_q == HALF) |-> (chip_o != $past(chip_o))) else $error("no mid-bit transition"); // R2

  AST_CNT_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q <= LAST) else $error("counter out of range"); // R3
endmodule

// File: rtl/mfsk_tune_ctrl.sv
module mfsk_tune_ctrl #(
  parameter int unsigned BIT_CYC = 4
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       bit_vld,
  input  logic       bit_in,
  input  logic [2:0] spacing,
  output logic       chip_o,
  output logic [5:0] tune_en
);
  import mfsk_pkg::*;

  logic [1:0]         rst_pipe_q;
  logic               rst_core_n;
  logic [1:0]         raw_in, sync_out;
  logic               seq_active;
  logic               seq_chip;
  logic [SPACE_W-1:0] seq_code;
  logic [CAP_W-1:0]   therm;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe_q <= 2'b00;
    else        rst_pipe_q <= {rst_pipe_q[0], 1'b1};
  end
  assign rst_core_n = rst_pipe_q[1];

  assign raw_in = {bit_vld, bit_in};

  mfsk_sync2 #(.W(2), .STAGES(SYNC_STAGES)) u_sync (
    .clk   (clk),
    .rst_n (rst_core_n),
    .d_i   (raw_in),
    .q_o   (sync_out)
  );

  mfsk_bit_seq #(.BIT_CYC(BIT_CYC), .CODE_W(SPACE_W)) u_seq (
    .clk      (clk),
    .rst_n    (rst_core_n),
    .vld_s    (sync_out[1]),
    .bit_s    (sync_out[0]),
    .code_i   (spacing),
    .active_o (seq_active),
    .chip_o   (seq_chip),
    .code_o   (seq_code)
  );

  mfsk_therm_dec #(.CODE_W(SPACE_W), .EN_W(CAP_W)) u_dec (
    .code_i  (seq_code),
    .therm_o (therm)
  );

  assign chip_o  = seq_chip;
  assign tune_en = seq_chip ? '0 : therm;

  AST_IDLE_STATE: assert property (@(posedge clk) disable iff (!rst_core_n)
    !seq_active |-> (chip_o && tune_en == '0)) else $error("not idle"); // R1

  AST_HIGH_CHIP_OFF: assert property (@(posedge clk) disable iff (!rst_core_n)
    chip_o |-> (tune_en == '0)) else $error("caps on during high chip"); // R4

  AST_THERM_SHAPE: assert property (@(posedge clk) disable iff (!rst_core_n)
    !chip_o |-> (tune_en[0] && ((tune_en & (tune_en + 6'd1)) == '0))) else $error("not thermometer"); // R5

  AST_SAT_CODE: assert property (@(posedge clk) disable iff (!rst_core_n)
    (!chip_o && seq_code >= 3'd5) |-> (&tune_en)) else $error("no saturation"); // R6
endmodule

// File: tb/mfsk_tune_ctrl_bench.sv
module mfsk_tune_ctrl_bench;
  localparam int BIT_CYC = 4;
  localparam int HALF = BIT_CYC / 2;

  typedef struct {
    int         due;
    logic       chip;
    logic [5:0] tune;
    string      req;
  } exp_t;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       bit_vld = 1'b0;
  logic       bit_in = 1'b0;
  logic [2:0] spacing = 3'd0;
  logic       chip_o;
  logic [5:0] tune_en;

  int   cyc = 0;
  int   checks = 0;
  int   failures = 0;
  bit   mon_on = 1'b0;
  bit   done = 1'b0;
  exp_t sb_q[$];

  mfsk_tune_ctrl #(.BIT_CYC(BIT_CYC)) u_mfsk_tune_ctrl (
    .clk(clk), .rst_n(rst_n), .bit_vld(bit_vld), .bit_in(bit_in),
    .spacing(spacing), .chip_o(chip_o), .tune_en(tune_en)
  );

  always #5 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  function automatic logic [5:0] therm_of(input logic [2:0] code);
    int n = (code > 3'd5) ? 5 : int'(code);
    return 6'((1 << (n + 1)) - 1);
  endfunction

  task automatic check(input string req, input logic c, input logic [5:0] t,
                       input logic ec, input logic [5:0] et);
    checks++;
    if (c !== ec || t !== et) begin
      failures++;
      $display("FAIL %s cyc=%0d chip=%b tune=%b expected chip=%b tune=%b",
               req, cyc, c, t, ec, et);
    end
  endtask

  // driver: call at a negedge; consumes BIT_CYC negedges
  task automatic send_bit(input logic b, input logic [2:0] code,
                          input logic [2:0] mid_code, input bit hold2,
                          input string req);
    int base = cyc;
    bit_vld = 1'b1;
    bit_in  = b;
    spacing = code;
    for (int i = 0; i < BIT_CYC; i++) begin
      exp_t e;
      e.due  = base + 3 + i;
      e.chip = (i < HALF) ? b : ~b;
      e.tune = e.chip ? 6'd0 : therm_of(code);
      e.req  = req;
      sb_q.push_back(e);
    end
    for (int i = 0; i < BIT_CYC; i++) begin
      @(negedge clk);
      if (i == 0 && !hold2) bit_vld = 1'b0;
      if (i == 1) bit_vld = 1'b0;
      if (i == 2) spacing = mid_code;
    end
  endtask

  // monitor
  always @(negedge clk) begin
    if (mon_on) begin
      exp_t e;
      if (sb_q.size() > 0 && sb_q[0].due == cyc) begin
        e = sb_q.pop_front();
      end else begin
        e.due = cyc; e.chip = 1'b1; e.tune = 6'd0; e.req = "R1 idle";
      end
      check(e.req, chip_o, tune_en, e.chip, e.tune);
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      failures++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    // R1: reset state
    repeat (2) begin
      @(negedge clk);
      check("R1 reset", chip_o, tune_en, 1'b1, 6'd0);
    end
    rst_n = 1'b1;
    repeat (5) @(negedge clk);
    mon_on = 1'b1;
    repeat (2) @(negedge clk);

    // R2, R3, R5: both bit values, gap-free stream across codes 0..5
    send_bit(1'b1, 3'd0, 3'd0, 1'b0, "R2/R3 bit1 code0");
    send_bit(1'b0, 3'd0, 3'd0, 1'b0, "R2/R3 bit0 code0");
    for (int k = 1; k <= 5; k++)
      send_bit(k[0], 3'(k), 3'(k), 1'b0, "R5 thermometer");
    // R6: saturated codes
    send_bit(1'b0, 3'd6, 3'd6, 1'b0, "R6 code6");
    send_bit(1'b1, 3'd7, 3'd7, 1'b0, "R6 code7");
    // R4: high-chip check covered by all items; idle gap
    repeat (4) @(negedge clk);
    // R7: spacing change inside a bit ignored, used on next bit
    send_bit(1'b0, 3'd2, 3'd5, 1'b0, "R7 hold code");
    send_bit(1'b0, 3'd5, 3'd5, 1'b0, "R7 new code");
    repeat (4) @(negedge clk);
    // R8: strobe held two cycles, second copy arrives mid-bit and is dropped
    send_bit(1'b1, 3'd1, 3'd1, 1'b1, "R8 drop mid-bit");
    repeat (6) @(negedge clk);

    // R9: asynchronous reset in the middle of a bit
    mon_on = 1'b0;
    bit_vld = 1'b1; bit_in = 1'b0; spacing = 3'd4;
    @(negedge clk); bit_vld = 1'b0;
    repeat (3) @(negedge clk);
    check("R9 bit running", chip_o, tune_en, 1'b0, 6'b011111);
    #2 rst_n = 1'b0;
    #1 check("R9 async idle", chip_o, tune_en, 1'b1, 6'd0);
    @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    mon_on = 1'b1;
    repeat (6) @(negedge clk);
    mon_on = 1'b0;
    if (sb_q.size() != 0) begin
      failures++;
      $display("FAIL R3 %0d expected chips never checked, expected 0", sb_q.size());
    end

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule